// File: doc/BRIEF.md
# Per-Hart Software Interrupt Register Bank

This block lets software on any core raise a software interrupt (an inter-processor interrupt) on any of `NUM_HARTS` harts. Each hart owns one 32-bit register in a small address window; bit 0 of that register drives the hart's pending line `irq_pending[i]`. Requests arrive on a valid/ready request channel and each accepted request, read or write, returns exactly one response on a valid/ready response channel.

A build-time parameter `MODE` selects one of two behaviours. In `MODE_RW` the bit is an ordinary register: software can set it, clear it and read it back, and the hart's acknowledge input has no effect. In `MODE_DOORBELL` the register is set-only: writing 0 does nothing, every read returns 0, and the only way to drop a pending line is a pulse on that hart's `ack_clr` input. Doorbell state is deliberately not touched by reset.

The request channel accepts a request whenever no response is waiting or the waiting response is being taken in the same cycle. A response stays valid, with its data unchanged, until `rsp_ready` is high. While a response is stalled, `req_ready` is low and no request takes effect.

Top module: `sw_irq_bank`

## Requirements
- R1: Hart i's register is at byte address 4*i; the word index is `req_addr[ADDR_W-1:2]`. A word index of `NUM_HARTS` or more is invalid: its reads return 0 and its writes change no pending line.
- R2: Only requests with `req_size` = 2'b10 (32-bit) and `req_addr[1:0]` = 2'b00 are valid; any other size or alignment reads 0 and writes are ignored.
- R3: A valid accepted write with `req_wdata[0]` = 1 sets `irq_pending[i]`, visible right after the accepting clock edge, in both modes.
- R4: In `MODE_RW`, a valid accepted write with `req_wdata[0]` = 0 clears `irq_pending[i]` right after the accepting edge.
- R5: In `MODE_DOORBELL`, a write of bit 0 = 0 has no effect; `irq_pending[i]` clears only on an edge where `ack_clr[i]` is high, and a set write to the same hart on that edge wins.
- R6: In `MODE_RW`, a valid read returns the hart's pending bit in `rsp_rdata[0]`; in `MODE_DOORBELL` every read returns 0. Write responses carry 0.
- R7: Bits 31:1 of `req_wdata` have no effect, and `rsp_rdata[31:1]` is always 0.
- R8: Reset (`rst_n` low) clears the response channel; in `MODE_RW` it also clears all pending bits, while in `MODE_DOORBELL` it leaves them unchanged.
- R9: In `MODE_RW`, `ack_clr` has no effect on any pending line.
- R10: `req_ready` is high exactly when `rsp_valid` is low or `rsp_ready` is high; an accepted request yields `rsp_valid` after that edge, and a stalled response holds its data until taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the bank |
| req_size | input | 2 | Access size code, 2'b10 = 32 bits |
| req_wdata | input | 32 | Write data, only bit 0 is used |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken this cycle |
| rsp_rdata | output | 32 | Read data, 0 for writes and invalid requests |
| ack_clr | input | NUM_HARTS | Per-hart acknowledge, clears in doorbell mode |
| irq_pending | output | NUM_HARTS | Per-hart software interrupt lines |

## Verification
Every result of this block is due one clock edge after its cause: a pending line changes on the edge that accepts the write or samples `ack_clr`, and the response for a request appears on that same edge. The bench therefore drives each stimulus at a falling edge and samples outputs at the next falling edge, so exactly one rising edge separates cause and check. For the stalled-response case it checks after each rising edge that the response data held and that a waiting write left the pending lines alone, and only after `rsp_ready` returns does it expect the write to land on the following edge.

// File: rtl/sw_irq_pkg.sv
package sw_irq_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } acc_size_e;

  typedef enum logic {
    MODE_RW       = 1'b0,
    MODE_DOORBELL = 1'b1
  } swi_mode_e;
endpackage

// File: rtl/swi_decode.sv
module swi_decode #(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [1:0]           size,
  output logic                 legal,
  output logic [NUM_HARTS-1:0] hit
);
  import sw_irq_pkg::*;
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  assign idx   = addr[ADDR_W-1:2];
  assign legal = (size == SZ_WORD) && (addr[1:0] == 2'b00) && (int'(idx) < NUM_HARTS);

  for (genvar g = 0; g < NUM_HARTS; g++) begin : g_hit
    assign hit[g] = legal && (int'(idx) == g);
  end
endmodule

// File: rtl/swi_cell.sv
module swi_cell #(
  parameter sw_irq_pkg::swi_mode_e MODE = sw_irq_pkg::MODE_RW
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  input  logic ack,
  output logic pend
);
  import sw_irq_pkg::*;

  if (MODE == MODE_RW) begin : g_rw
    logic unused_ack;
    assign unused_ack = ack;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend <= 1'b0;
      else if (set_req) pend <= 1'b1;
      else if (clr_req) pend <= 1'b0;
    end
  end else begin : g_doorbell
    logic unused_in;
    assign unused_in = rst_n ^ clr_req;
    always_ff @(posedge clk) begin
      if (set_req)  pend <= 1'b1;
      else if (ack) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/swi_rsp.sv
module swi_rsp #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic [W-1:0] rdata_in,
  input  logic         rsp_ready,
  output logic         req_ready,
  output logic         rsp_valid,
  output logic [W-1:0] rsp_rdata
);
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rdata_in;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sw_irq_bank.sv
module sw_irq_bank #(
  parameter int                    NUM_HARTS = 4,
  parameter int                    ADDR_W    = 8,
  parameter sw_irq_pkg::swi_mode_e MODE      = sw_irq_pkg::MODE_RW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [31:0]          rsp_rdata,
  input  logic [NUM_HARTS-1:0] ack_clr,
  output logic [NUM_HARTS-1:0] irq_pending
);
  import sw_irq_pkg::*;
  localparam logic READABLE = (MODE == MODE_RW);

  logic                 accept, wr, legal, rd_bit;
  logic [NUM_HARTS-1:0] hit;
  logic [REG_W-1:0]     rdata_next;
  logic                 unused_hi;

  assign unused_hi = ^req_wdata[31:1];
  assign accept    = req_valid && req_ready;
  assign wr        = accept && req_write;

  swi_decode #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .size (req_size),
    .legal(legal),
    .hit  (hit)
  );

  for (genvar g = 0; g < NUM_HARTS; g++) begin : g_cell
    swi_cell #(.MODE(MODE)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_req(wr && hit[g] && req_wdata[0]),
      .clr_req(wr && hit[g] && !req_wdata[0]),
      .ack    (ack_clr[g]),
      .pend   (irq_pending[g])
    );
  end

  assign rd_bit     = READABLE && legal && !req_write && |(irq_pending & hit);
  assign rdata_next = {{(REG_W-1){1'b0}}, rd_bit};

  swi_rsp #(.W(REG_W)) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .rdata_in (rdata_next),
    .rsp_ready(rsp_ready),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/sw_irq_bank_chk.sv
module sw_irq_bank_chk #(
  parameter int                    NUM_HARTS = 4,
  parameter int                    ADDR_W    = 8,
  parameter sw_irq_pkg::swi_mode_e MODE      = sw_irq_pkg::MODE_RW
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_write,
  input logic [ADDR_W-1:0]    req_addr,
  input logic [1:0]           req_size,
  input logic [31:0]          req_wdata,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [31:0]          rsp_rdata,
  input logic [NUM_HARTS-1:0] ack_clr,
  input logic [NUM_HARTS-1:0] irq_pending
);
  import sw_irq_pkg::*;

  logic                 acc, legal, unused_hi;
  logic [ADDR_W-3:0]    idx;
  logic [NUM_HARTS-1:0] want_set, want_clr;

  assign unused_hi = ^req_wdata[31:1];
  assign acc   = req_valid && req_ready;
  assign idx   = req_addr[ADDR_W-1:2];
  assign legal = (req_size == SZ_WORD) && (req_addr[1:0] == 2'b00) && (int'(idx) < NUM_HARTS);

  always_comb begin
    want_set = '0;
    want_clr = '0;
    for (int i = 0; i < NUM_HARTS; i++) begin
      if (acc && req_write && legal && int'(idx) == i) begin
        want_set[i] = req_wdata[0];
        want_clr[i] = !req_wdata[0];
      end
    end
  end

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (|want_set) |=> ((irq_pending & $past(want_set)) == $past(want_set))); // R3
  AST_RW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((MODE == MODE_RW) && |want_clr) |=> ((irq_pending & $past(want_clr)) == '0)); // R4
  AST_DOORBELL_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((MODE == MODE_DOORBELL) && |want_clr && ((ack_clr & want_clr) == '0))
    |=> ((irq_pending & $past(want_clr)) == $past(irq_pending & want_clr))); // R5
  AST_DOORBELL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((MODE == MODE_DOORBELL) && rsp_valid) |-> (rsp_rdata == '0)); // R6
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[31:1] == '0)); // R7
  AST_BAD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && !legal && ack_clr == '0) |=> $stable(irq_pending)); // R1
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(acc && req_write) && ack_clr == '0) |=> $stable(irq_pending)); // R9
  AST_RW_RESET_CLEAR: assert property (@(posedge clk)
    ((MODE == MODE_RW) && !rst_n) |=> (irq_pending == '0)); // R8
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R10
  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (!rsp_valid || rsp_ready)); // R10
endmodule

bind sw_irq_bank sw_irq_bank_chk #(
  .NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W), .MODE(MODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
  .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .ack_clr(ack_clr), .irq_pending(irq_pending)
);

// File: tb/tb_sw_irq_bank.sv
`timescale 1ns/1ps
module tb_sw_irq_bank;
  import sw_irq_pkg::*;
  localparam int N  = 4;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr  = '0;
  logic [1:0]    req_size  = '0;
  logic [31:0]   req_wdata = '0;
  logic [N-1:0]  ack_clr   = '0;

  logic rdy_m, rdy_s, rv_m, rv_s;
  logic [31:0] rd_m, rd_s;
  logic [N-1:0] irq_m, irq_s;
  logic [N-1:0] exp_m = '0, exp_s = '0;
  int n_chk = 0, n_bad = 0;

  sw_irq_bank #(.NUM_HARTS(N), .ADDR_W(AW), .MODE(MODE_RW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_m),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rv_m), .rsp_ready(rsp_ready),
    .rsp_rdata(rd_m), .ack_clr(ack_clr), .irq_pending(irq_m));

  sw_irq_bank #(.NUM_HARTS(N), .ADDR_W(AW), .MODE(MODE_DOORBELL)) dut_sv (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_s),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rv_s), .rsp_ready(rsp_ready),
    .rsp_rdata(rd_s), .ack_clr(ack_clr), .irq_pending(irq_s));

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // One request, response and state checked one rising edge later.
  task automatic do_req(input logic wr, input int word, input int off, input logic [1:0] sz,
                        input logic [31:0] wd);
    logic legal;
    logic [31:0] em;
    string t;
    legal = (sz == 2'b10) && (off == 0) && (word < N);
    t = !legal ? ((word >= N) ? "R1" : "R2") : (wr ? (wd[0] ? "R3" : "R4 R5") : "R6 R7");
    em = '0;
    if (!wr && legal) em = {31'b0, exp_m[word]};
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(word * 4 + off);
    req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (wr && legal) begin
      exp_m[word] = wd[0];
      if (wd[0]) exp_s[word] = 1'b1;
    end
    cmp("R10", "rsp_valid", {31'b0, rv_m}, 32'd1);
    cmp(t, "machine rdata", rd_m, em);
    cmp(t, "doorbell rdata", rd_s, 32'd0);
    cmp(t, "machine pending", {28'b0, irq_m}, {28'b0, exp_m});
    cmp(t, "doorbell pending", {28'b0, irq_s}, {28'b0, exp_s});
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL R10 watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    ack_clr = '1;
    repeat (3) @(negedge clk);
    ack_clr = '0;
    cmp("R8", "reset machine pending", {28'b0, irq_m}, 32'd0);
    cmp("R8", "reset rsp_valid", {31'b0, rv_m}, 32'd0);
    cmp("R10", "ready idle", {31'b0, rdy_m}, 32'd1);
    rst_n = 1'b1;

    // Sweep every word index, size code and byte offset (R1 R2 R3 R4 R5 R6 R7)
    for (int w = 0; w < 16; w++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 4; off++) begin
          do_req(1'b1, w, off, 2'(sz), 32'hA5A5_5A5B);
          do_req(1'b0, w, off, 2'(sz), 32'h0);
          do_req(1'b1, w, off, 2'(sz), 32'h5A5A_A5A4);
          do_req(1'b0, w, off, 2'(sz), 32'h0);
        end

    for (int h = 0; h < N; h++) do_req(1'b1, h, 0, 2'b10, 32'h1);

    // Acknowledge pulse: R9 machine ignores, R5 doorbell clears
    @(negedge clk);
    ack_clr = 4'b0101;
    @(negedge clk);
    ack_clr = '0;
    exp_s = exp_s & ~4'b0101;
    cmp("R9", "machine pending after ack", {28'b0, irq_m}, {28'b0, exp_m});
    cmp("R5", "doorbell pending after ack", {28'b0, irq_s}, {28'b0, exp_s});

    // R5: set write and acknowledge on the same edge, set wins
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(0); req_size = 2'b10;
    req_wdata = 32'h1; ack_clr = 4'b0001;
    @(negedge clk);
    req_valid = 1'b0; ack_clr = '0;
    exp_s[0] = 1'b1;
    cmp("R5", "set beats ack", {28'b0, irq_s}, {28'b0, exp_s});

    // R8: reset clears machine bits, leaves doorbell bits
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    exp_m = '0;
    cmp("R8", "machine pending in reset", {28'b0, irq_m}, 32'd0);
    cmp("R8", "doorbell kept in reset", {28'b0, irq_s}, {28'b0, exp_s});
    rst_n = 1'b1;

    // R10: back-pressure on the response channel
    do_req(1'b1, 1, 0, 2'b10, 32'h1);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(4); req_size = 2'b10;
    @(negedge clk);
    req_write = 1'b1; req_wdata = 32'h0;
    cmp("R10", "stalled rsp_valid", {31'b0, rv_m}, 32'd1);
    cmp("R10", "stalled rdata", rd_m, 32'd1);
    cmp("R10", "ready low while stalled", {31'b0, rdy_m}, 32'd0);
    @(negedge clk);
    cmp("R10", "rdata held", rd_m, 32'd1);
    cmp("R10", "write blocked", {28'b0, irq_m}, {28'b0, exp_m});
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    exp_m[1] = 1'b0;
    cmp("R10", "write after release", {28'b0, irq_m}, {28'b0, exp_m});
    cmp("R10", "write response", {31'b0, rv_m}, 32'd1);
    cmp("R10", "write response data", rd_m, 32'd0);
    cmp("R5", "doorbell zero write", {28'b0, irq_s}, {28'b0, exp_s});
    @(negedge clk);
    cmp("R10", "response drained", {31'b0, rv_m}, 32'd0);

    finish_run();
  end
endmodule